// File: doc/BRIEF.md
# Rotate-and-Masked Flag Insert Unit

This block is a one-instruction execute stage for a processor pipeline. Each cycle it may receive one 32-bit instruction word with a valid strobe. It also receives a feature-enable level and the 64-bit operand that a register file returns for the source index the block exposes. When the word is the flag-insert instruction, the operand is rotated right by a 6-bit immediate. The four lowest bits of the rotated value then go, under a 4-bit immediate mask, into a registered four-flag condition register (negative, zero, carry, overflow). Flags whose mask bit is clear keep their value.

A word that has the instruction's shape but is not allowed raises a one-cycle undefined-instruction pulse and writes no flag. This happens when the width selector is clear or the feature is disabled. Any other word is ignored silently. The unit accepts one word in every cycle and has no back-pressure. The operand must be valid in the same cycle as the word, because the source index is a combinational decode of that word. The result is always ready one clock edge later, whatever the operand or the flag contents.

Top module: `flag_rotins_unit`

## Requirements
- R1: A word matches the instruction shape only when bit 30 is 0, bit 29 is 1, bits 28:21 are 8'b11010000, bits 14:10 are 5'b00001 and bit 4 is 0. A matching valid word with bit 31 set and feature enable high updates the flags.
- R2: A valid, shape-matching word with bit 31 clear drives `undef_pulse` high for exactly one cycle after the edge and leaves all flags unchanged.
- R3: A valid, shape-matching word while `feat_en` is low drives `undef_pulse` high for one cycle and leaves all flags unchanged.
- R4: A valid word that fails any fixed-bit test in R1, or any word with `insn_vld` low, changes no flag and raises no pulse.
- R5: Bits 20:15 give a rotate-right amount from 0 to 63. The inserted 4-bit value is bits lsb+3..lsb of the operand concatenated with itself, so amounts 61 to 63 wrap into operand bit 0.
- R6: Mask bit 3 (word bit 3) writes flag bit 3 (N) from rotated bit 3. Mask bit 2 writes Z (flag bit 2) from rotated bit 2. Mask bit 1 writes C (flag bit 1) from rotated bit 1. Mask bit 0 writes V (flag bit 0) from rotated bit 0.
- R7: Each flag whose mask bit is 0 keeps its previous value. A mask of 0 leaves all four flags unchanged.
- R8: Every result appears on `flags_q` exactly one edge after the word is presented, independent of operand and flag values. Back-to-back words are each applied in order.
- R9: A synchronous active-high reset clears `flags_q` to 4'b0000 and `undef_pulse` to 0.
- R10: `src_idx` equals word bits 9:5 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_vld | input | 1 | Instruction word valid this cycle |
| insn_word | input | 32 | Instruction word |
| feat_en | input | 1 | Flag-manipulation feature enable |
| src_idx | output | 5 | Source register index to the register file |
| src_data | input | 64 | Operand read for `src_idx` |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |
| undef_pulse | output | 1 | One-cycle undefined-instruction indication |

## Verification
The bench builds the unit with its default 64-bit operand, a 6-bit rotate field and four flags. With those values every rotate amount and every mask can be swept exhaustively, including the three amounts that wrap past bit 63. Random operands and fixed one-hot patterns near both ends of the operand show whether each wrapped bit lands in the right flag. Single-bit corruptions of each fixed opcode field, together with a cleared width bit and a disabled feature, exercise the split between the silent-ignore path and the undefined path.

// File: rtl/flagrot_pkg.sv
package flagrot_pkg;
  localparam int OPND_W  = 64;
  localparam int AMT_W   = $clog2(OPND_W);
  localparam int NFLAG   = 4;
  localparam int IDX_W   = 5;

  // Fixed opcode fields; positions are part of the instruction encoding.
  localparam logic [7:0] MAJOR_OPC = 8'b1101_0000;
  localparam logic [4:0] MINOR_OPC = 5'b00001;

  typedef struct packed {
    logic             shape_ok;
    logic             exec;
    logic             undef_req;
    logic [AMT_W-1:0] amt;
    logic [NFLAG-1:0] mask;
    logic [IDX_W-1:0] src;
  } dec_t;
endpackage

// File: rtl/flagrot_decode.sv
module flagrot_decode
  import flagrot_pkg::*;
(
  input  logic        vld,
  input  logic [31:0] word,
  input  logic        feat_en,
  output dec_t        dec
);
  logic fixed_ok;
  logic allowed;

  always_comb begin
    fixed_ok = (word[30] == 1'b0) && (word[29] == 1'b1) &&
               (word[28:21] == MAJOR_OPC) && (word[14:10] == MINOR_OPC) &&
               (word[4] == 1'b0);
    allowed  = word[31] & feat_en;

    dec.shape_ok  = vld & fixed_ok;
    dec.exec      = vld & fixed_ok & allowed;
    dec.undef_req = vld & fixed_ok & ~allowed;
    dec.amt       = word[20:15];
    dec.src       = word[9:5];
    dec.mask      = word[3:0];
  end
endmodule

// File: rtl/flagrot_rotate.sv
module flagrot_rotate #(
  parameter int DATA_W = 64,
  parameter int OUT_W  = 4,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [SEL_W-1:0]  amt,
  output logic [OUT_W-1:0]  nib
);
  // Each output bit picks one operand bit; the index wraps modulo DATA_W,
  // which is the same as slicing the operand concatenated with itself.
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    logic [SEL_W-1:0] pos;
    assign pos    = amt + SEL_W'(i);
    assign nib[i] = opnd[pos];
  end
endmodule

// File: rtl/flagrot_flagreg.sv
module flagrot_flagreg #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [NF-1:0] mask,
  input  logic [NF-1:0] nib,
  output logic [NF-1:0] flags_q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                  flags_q[i] <= 1'b0;
      else if (wr_en && mask[i]) flags_q[i] <= nib[i];
    end

    // R7: an unselected flag holds across a write
    a_r7_masked_hold: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !mask[i]) |=> (flags_q[i] == $past(flags_q[i])));
  end

  // R6: selected flags take the rotated bits
  a_r6_selected_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((flags_q & $past(mask)) == ($past(nib) & $past(mask))));

  // R4: no write request, no change
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flags_q));
endmodule

// File: rtl/flag_rotins_unit.sv
module flag_rotins_unit
  import flagrot_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_vld,
  input  logic [31:0]       insn_word,
  input  logic              feat_en,
  output logic [IDX_W-1:0]  src_idx,
  input  logic [OPND_W-1:0] src_data,
  output logic [NFLAG-1:0]  flags_q,
  output logic              undef_pulse
);
  dec_t             dec;
  logic [NFLAG-1:0] rot_nib;

  flagrot_decode u_dec (
    .vld     (insn_vld),
    .word    (insn_word),
    .feat_en (feat_en),
    .dec     (dec)
  );

  assign src_idx = dec.src;

  flagrot_rotate #(.DATA_W(OPND_W), .OUT_W(NFLAG)) u_rot (
    .opnd (src_data),
    .amt  (dec.amt),
    .nib  (rot_nib)
  );

  flagrot_flagreg #(.NF(NFLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (dec.exec),
    .mask    (dec.mask),
    .nib     (rot_nib),
    .flags_q (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) undef_pulse <= 1'b0;
    else     undef_pulse <= dec.undef_req;
  end

  // R2/R3: an undefined word writes no flag
  a_r2_undef_no_write: assert property (@(posedge clk) disable iff (rst)
    undef_pulse |-> $stable(flags_q));

  // R4: a non-matching valid word is silent
  a_r4_silent_ignore: assert property (@(posedge clk) disable iff (rst)
    (insn_vld && !dec.shape_ok) |=> (!undef_pulse && $stable(flags_q)));

  // R8: an executed word never yields an undefined pulse next cycle
  a_r8_exec_clean: assert property (@(posedge clk) disable iff (rst)
    dec.exec |=> !undef_pulse);

  // R10: source index follows word bits 9:5
  always_comb begin
    a_r10_src_idx: assert (src_idx == insn_word[9:5]);
  end
endmodule

// File: tb/flag_rotins_unit_test.sv
`timescale 1ns/1ps
module flag_rotins_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        insn_vld;
  logic [31:0] insn_word;
  logic        feat_en;
  logic [4:0]  src_idx;
  logic [63:0] src_data;
  logic [3:0]  flags_q;
  logic        undef_pulse;

  int total = 0;
  int bad   = 0;

  logic [3:0] exp_flags;
  logic       exp_undef;

  always #2 clk = ~clk;

  flag_rotins_unit uut (
    .clk(clk), .rst(rst), .insn_vld(insn_vld), .insn_word(insn_word),
    .feat_en(feat_en), .src_idx(src_idx), .src_data(src_data),
    .flags_q(flags_q), .undef_pulse(undef_pulse)
  );

  function automatic logic [31:0] mk(input logic sf, input logic [5:0] sh,
                                     input logic [4:0] rn, input logic [3:0] m);
    return {sf, 1'b0, 1'b1, 8'b1101_0000, sh, 5'b00001, rn, 1'b0, m};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference for one accepted cycle
  task automatic model(input logic v, input logic [31:0] w, input logic fe,
                       input logic [63:0] d);
    logic [127:0] dbl;
    logic [3:0]   t;
    bit shape;
    int lsb;
    shape = (w[30] == 0) && (w[29] == 1) && (w[28:21] == 8'hD0) &&
            (w[14:10] == 5'd1) && (w[4] == 0);
    lsb = int'(w[20:15]);
    dbl = {d, d};
    t   = 4'(dbl >> lsb);
    exp_undef = 1'b0;
    if (v && shape) begin
      if (w[31] && fe) begin
        for (int k = 0; k < 4; k++) if (w[k]) exp_flags[k] = t[k];
      end else exp_undef = 1'b1;
    end
  endtask

  // Drive on the falling edge, model on the rising edge, compare at next fall
  task automatic step(input string req, input logic v, input logic [31:0] w,
                      input logic fe, input logic [63:0] d);
    insn_vld = v; insn_word = w; feat_en = fe; src_data = d;
    #0.5;
    chk("R10", 32'(src_idx), 32'(w[9:5]));
    @(posedge clk);
    model(v, w, fe, d);
    @(negedge clk);
    chk(req, 32'(flags_q), 32'(exp_flags));
    chk(req, 32'(undef_pulse), 32'(exp_undef));
  endtask

  task automatic do_reset();
    rst = 1'b1; insn_vld = 0; insn_word = 0; feat_en = 1; src_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_flags = 4'b0; exp_undef = 1'b0;
    chk("R9", 32'(flags_q), 32'h0);
    chk("R9", 32'(undef_pulse), 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    @(negedge clk);
    do_reset();

    // R1: plain matching word, all flags
    step("R1", 1, mk(1, 6'd0, 5'd3, 4'hF), 1, 64'h5);
    step("R1", 1, mk(1, 6'd4, 5'd7, 4'hF), 1, 64'hA0);

    // R5/R6: every shift and every mask with random data
    for (int sh = 0; sh < 64; sh++) begin
      for (int m = 0; m < 16; m++) begin
        d = {$urandom, $urandom};
        step(sh >= 61 ? "R5" : (m == 0 ? "R7" : "R6"),
             1, mk(1, 6'(sh), 5'(m), 4'(m)), 1, d);
      end
    end

    // R5: wrap with one-hot patterns
    for (int sh = 61; sh < 64; sh++) begin
      for (int b = 0; b < 4; b++) begin
        step("R5", 1, mk(1, 6'd0, 5'd1, 4'hF), 1, 64'hF);
        step("R5", 1, mk(1, 6'(sh), 5'd2, 4'hF), 1, 64'd1 << b);
        step("R5", 1, mk(1, 6'(sh), 5'd2, 4'hF), 1, 64'd1 << 63);
      end
    end

    // R6: single-flag masks, one bit each
    for (int m = 0; m < 4; m++) begin
      step("R6", 1, mk(1, 6'd0, 5'd0, 4'hF), 1, 64'h0);
      step("R6", 1, mk(1, 6'd0, 5'd0, 4'(1 << m)), 1, 64'hF);
    end

    // R7: mask zero over set flags
    step("R7", 1, mk(1, 6'd0, 5'd0, 4'hF), 1, 64'hF);
    step("R7", 1, mk(1, 6'd0, 5'd0, 4'h0), 1, 64'h0);

    // R2: width bit clear
    step("R2", 1, mk(1, 6'd0, 5'd0, 4'hF), 1, 64'h9);
    step("R2", 1, mk(0, 6'd0, 5'd0, 4'hF), 1, 64'h6);
    step("R2", 0, 32'h0, 1, 64'h0);

    // R3: feature disabled
    step("R3", 1, mk(1, 6'd2, 5'd9, 4'hF), 0, 64'hFF);
    step("R3", 1, mk(1, 6'd2, 5'd9, 4'hF), 1, 64'h0);

    // R4: corrupt each fixed bit, then valid low with a good word
    step("R4", 1, mk(1, 6'd0, 5'd0, 4'hF), 1, 64'hF);
    for (int b = 4; b < 31; b++) begin
      if (b == 4 || (b >= 10 && b <= 14) || (b >= 21)) begin
        step("R4", 1, mk(1, 6'd0, 5'd0, 4'hF) ^ (32'd1 << b), 1, 64'h0);
      end
    end
    step("R4", 0, mk(1, 6'd0, 5'd0, 4'hF), 1, 64'h0);
    step("R4", 0, mk(0, 6'd0, 5'd0, 4'hF), 0, 64'h0);

    // R8: back-to-back stream with data-heavy and data-light operands
    for (int k = 0; k < 32; k++) begin
      step("R8", 1, mk(1, 6'(k * 7), 5'(k), 4'(k + 1)), 1,
           (k % 2) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
    end

    // R9: reset from a non-zero state
    step("R9", 1, mk(1, 6'd0, 5'd0, 4'hF), 1, 64'hF);
    @(negedge clk);
    do_reset();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule